// File: doc/BRIEF.md
# Four-Channel Pulse Coincidence Filter

This block sits behind a cluster of four neighbouring photon detectors. In each sample cycle it takes one timing pulse per detector. It reports a coincidence when at least a programmed number of those pulses are high in the same cycle. Background photons arrive at random times and seldom line up across detectors, while a returning laser echo reaches the whole cluster at once. Raising the required count therefore rejects ambient noise before the pulse reaches a downstream time-to-digital converter.

The number of simultaneous pulses is found by a small network of two-input sorter cells. Each cell gives the OR and the AND of its two inputs. The network produces four level lines: at least one, at least two, at least three, and all four. A one-hot threshold word picks which level line drives the coincidence result. A separate path merges four counting pulses into a single counting strobe. A mode bit selects whether the timing result or the counting strobe drives the shared data output. All outputs are registered, so each one appears one cycle after the inputs that caused it.

Top module: `pulse_coinc_filter`

## Requirements
- R1: With threshold word 4'b0001 (bit 0 set), the coincidence output is high whenever at least one timing input was high.
- R2: With threshold word 4'b0010 (bit 1 set), the coincidence output is high exactly when two or more timing inputs were high in the same cycle.
- R3: With threshold word 4'b0100 (bit 2 set), the coincidence output is high exactly when three or more timing inputs were high in the same cycle.
- R4: With threshold word 4'b1000 (bit 3 set), the coincidence output is high only when all four timing inputs were high in the same cycle.
- R5: A threshold word that is not one-hot (all zeros, or two or more bits set) forces the coincidence output low for every input pattern.
- R6: The error flag goes high one cycle after a non-one-hot threshold word is sampled. It stays high, even after a legal word returns, until reset.
- R7: The counting strobe output is the OR of the four counting inputs and is independent of the threshold word.
- R8: The data output carries the coincidence result when the mode bit is 0 and the counting strobe when the mode bit is 1. The mode bit is sampled in the same cycle as the pulses.
- R9: Every output changes exactly one clock cycle after the inputs that cause it. While reset is low, all outputs are low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tpulse_i | input | 4 | Timing pulses, one per detector |
| cpulse_i | input | 4 | Counting pulses, one per detector |
| level_mask_i | input | 4 | One-hot threshold word (bit k: at least k+1 coincident) |
| count_mode_i | input | 1 | 0 selects timing result, 1 selects counting strobe for data_o |
| coinc_o | output | 1 | Registered coincidence result |
| count_strobe_o | output | 1 | Registered OR of counting pulses |
| data_o | output | 1 | Registered mode-selected data pulse |
| mask_err_o | output | 1 | Sticky illegal-threshold flag |

## Verification
The assertions assume that the pulses are already synchronous to the clock. Each input stays stable for one whole cycle, and one cycle of high counts as one pulse. They also assume that the threshold word and mode bit are sampled on the same edge as the pulses they govern. The stimulus changes every input only on the falling edge and holds it through the next rising edge. It sweeps all sixteen threshold words against every timing pattern, every counting pattern and both modes. Before each threshold word it applies a fresh reset, so that the sticky flag's behaviour can be observed for that word alone.

// File: rtl/pcf_pkg.sv
// Shared constants and types for the pulse coincidence filter.
// Assumes a fixed cluster of four detectors, matching the sorter network.
package pcf_pkg;
    localparam int CH_N  = 4;        // detectors per cluster
    localparam int LVL_N = CH_N;     // one level line per possible count
    localparam int CNT_W = $clog2(LVL_N + 1);

    typedef logic [CH_N-1:0]  ch_vec_t;
    typedef logic [LVL_N-1:0] lvl_vec_t;

    typedef enum logic {
        OUT_TIMING = 1'b0,
        OUT_COUNT  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/pcf_sorter2.sv
// Two-input sorter cell: the high output is the OR of the inputs and the
// low output is the AND. Purely combinational; no assumptions on inputs.
module pcf_sorter2 (
    input  logic a_i,
    input  logic b_i,
    output logic hi_o,
    output logic lo_o
);
    // Sort the pair so that hi_o >= lo_o.
    always_comb begin
        hi_o = a_i | b_i;
        lo_o = a_i & b_i;
    end
endmodule

// File: rtl/pcf_sorter_net.sv
// Five-cell sorter network turning four pulses into thermometer level lines:
// level_o[k] is high when at least k+1 inputs are high.
// Assumes exactly four inputs (CH_N fixed by the package).
module pcf_sorter_net
    import pcf_pkg::*;
(
    input  ch_vec_t  pulse_i,
    output lvl_vec_t level_o
);
    logic pair0_any, pair0_both, pair1_any, pair1_both;
    logic cross_any, cross_both, both_any, both_all;
    logic mid_two, mid_three;

    // First rank: sort each neighbouring pair.
    pcf_sorter2 u_pair0 (.a_i(pulse_i[0]), .b_i(pulse_i[1]), .hi_o(pair0_any), .lo_o(pair0_both));
    pcf_sorter2 u_pair1 (.a_i(pulse_i[2]), .b_i(pulse_i[3]), .hi_o(pair1_any), .lo_o(pair1_both));
    // Second rank: merge the OR lines and the AND lines separately.
    pcf_sorter2 u_cross (.a_i(pair0_any),  .b_i(pair1_any),  .hi_o(cross_any), .lo_o(cross_both));
    pcf_sorter2 u_both  (.a_i(pair0_both), .b_i(pair1_both), .hi_o(both_any),  .lo_o(both_all));
    // Third rank: resolve the two middle levels.
    pcf_sorter2 u_mid   (.a_i(cross_both), .b_i(both_any),   .hi_o(mid_two),   .lo_o(mid_three));

    // Collect the thermometer levels.
    always_comb begin
        level_o[0] = cross_any;
        level_o[1] = mid_two;
        level_o[2] = mid_three;
        level_o[3] = both_all;
    end
endmodule

// File: rtl/pcf_level_pick.sv
// Applies a one-hot mask to the level lines. A mask with other than exactly
// one bit set yields no hit and raises the illegal indication.
module pcf_level_pick
    import pcf_pkg::*;
#(
    parameter int LVLS = LVL_N
) (
    input  logic [LVLS-1:0] level_i,
    input  logic [LVLS-1:0] mask_i,
    output logic            hit_o,
    output logic            illegal_o
);
    localparam int SUM_W = $clog2(LVLS + 1);

    logic [LVLS-1:0] gated;
    logic [SUM_W-1:0] set_bits;

    genvar g;
    generate
        for (g = 0; g < LVLS; g++) begin : g_gate
            // Pass a level line only where its mask bit is set.
            assign gated[g] = level_i[g] & mask_i[g];
        end
    endgenerate

    // Count set mask bits and form the guarded result.
    always_comb begin
        set_bits = '0;
        for (int k = 0; k < LVLS; k++) begin
            set_bits = set_bits + SUM_W'(mask_i[k]);
        end
        illegal_o = (set_bits != SUM_W'(1));
        hit_o     = (|gated) & ~illegal_o;
    end
endmodule

// File: rtl/pulse_coinc_filter.sv
// Four-channel coincidence filter with counting-strobe merge and output mode
// select. Assumes all pulse inputs are synchronous one-cycle pulses and the
// mask and mode are valid on the same edge as the pulses. All outputs are
// registered (one cycle latency); reset is synchronous and active low.
module pulse_coinc_filter
    import pcf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] tpulse_i,
    input  logic [CH_N-1:0] cpulse_i,
    input  logic [LVL_N-1:0] level_mask_i,
    input  logic            count_mode_i,
    output logic            coinc_o,
    output logic            count_strobe_o,
    output logic            data_o,
    output logic            mask_err_o
);
    lvl_vec_t  levels;
    logic      hit, illegal, strobe_d;
    out_mode_e mode;

    pcf_sorter_net u_net (.pulse_i(tpulse_i), .level_o(levels));

    pcf_level_pick #(.LVLS(LVL_N)) u_pick (
        .level_i  (levels),
        .mask_i   (level_mask_i),
        .hit_o    (hit),
        .illegal_o(illegal)
    );

    // Merge counting pulses and decode the output mode.
    always_comb begin
        strobe_d = |cpulse_i;
        mode     = out_mode_e'(count_mode_i);
    end

    // Register results, mode-selected data and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coinc_o        <= 1'b0;
            count_strobe_o <= 1'b0;
            data_o         <= 1'b0;
            mask_err_o     <= 1'b0;
        end else begin
            coinc_o        <= hit;
            count_strobe_o <= strobe_d;
            data_o         <= (mode == OUT_COUNT) ? strobe_d : hit;
            mask_err_o     <= mask_err_o | illegal;
        end
    end

    AST_ANY_PASSES:   assert property (@(posedge clk) disable iff (!rst_n)
        (level_mask_i == 4'b0001 && (|tpulse_i)) |=> coinc_o);                  // R1
    AST_TWO_NEEDED:   assert property (@(posedge clk) disable iff (!rst_n)
        (level_mask_i == 4'b0010 && $countones(tpulse_i) < 2) |=> !coinc_o);    // R2
    AST_THREE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mask_i == 4'b0100 && $countones(tpulse_i) >= 3) |=> coinc_o);    // R3
    AST_ALL_NEEDED:   assert property (@(posedge clk) disable iff (!rst_n)
        (level_mask_i == 4'b1000 && !(&tpulse_i)) |=> !coinc_o);                // R4
    AST_BAD_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(level_mask_i) != 1) |=> !coinc_o);                          // R5
    AST_ERR_SET:      assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(level_mask_i) != 1) |=> mask_err_o);                        // R6
    AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n)
        mask_err_o |=> mask_err_o);                                             // R6
    AST_STROBE_OR:    assert property (@(posedge clk) disable iff (!rst_n)
        (|cpulse_i) |=> count_strobe_o);                                        // R7
    AST_MODE_COUNT:   assert property (@(posedge clk) disable iff (!rst_n)
        count_mode_i |=> (data_o == count_strobe_o));                           // R8
    AST_MODE_TIMING:  assert property (@(posedge clk) disable iff (!rst_n)
        !count_mode_i |=> (data_o == coinc_o));                                 // R8
    AST_NO_SPURIOUS:  assert property (@(posedge clk) disable iff (!rst_n)
        (tpulse_i == '0) |=> !coinc_o);                                         // R9
endmodule

// File: tb/pulse_coinc_filter_tb_top.sv
module pulse_coinc_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] tpulse_i, cpulse_i, level_mask_i;
    logic       count_mode_i;
    logic       coinc_o, count_strobe_o, data_o, mask_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pulse_coinc_filter dut_i (
        .clk(clk), .rst_n(rst_n), .tpulse_i(tpulse_i), .cpulse_i(cpulse_i),
        .level_mask_i(level_mask_i), .count_mode_i(count_mode_i),
        .coinc_o(coinc_o), .count_strobe_o(count_strobe_o),
        .data_o(data_o), .mask_err_o(mask_err_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (mask=%b tp=%b cp=%b mode=%0b)",
                     req, act, exp, level_mask_i, tpulse_i, cpulse_i, count_mode_i);
        end
    endtask

    function automatic int ones(input logic [3:0] v);
        int n = 0;
        for (int k = 0; k < 4; k++) n += int'(v[k]);
        return n;
    endfunction

    // Expected coincidence from the threshold rules R1..R5.
    function automatic logic exp_coinc(input logic [3:0] m, input logic [3:0] t);
        case (m)
            4'b0001: return ones(t) >= 1;   // R1
            4'b0010: return ones(t) >= 2;   // R2
            4'b0100: return ones(t) >= 3;   // R3
            4'b1000: return ones(t) == 4;   // R4
            default: return 1'b0;           // R5
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tpulse_i = '1; cpulse_i = '1; count_mode_i = 1'b1;
        @(posedge clk); #1;
        check("R9 reset coinc", coinc_o, 1'b0);
        check("R9 reset strobe", count_strobe_o, 1'b0);
        check("R9 reset data", data_o, 1'b0);
        check("R9 reset err", mask_err_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic ec, es, err_exp;
        rst_n = 1'b0; tpulse_i = '0; cpulse_i = '0; level_mask_i = 4'b0001; count_mode_i = 1'b0;
        for (int m = 0; m < 16; m++) begin
            do_reset();
            level_mask_i = 4'(m);
            err_exp = 1'b0;
            for (int md = 0; md < 2; md++) begin
                for (int t = 0; t < 16; t++) begin
                    for (int c = 0; c < 16; c++) begin
                        @(negedge clk);
                        tpulse_i = 4'(t); cpulse_i = 4'(c); count_mode_i = md[0];
                        @(posedge clk); #1;
                        ec = exp_coinc(level_mask_i, tpulse_i);
                        es = (cpulse_i != 0);
                        if (ones(level_mask_i) != 1) err_exp = 1'b1;
                        check("R1-R5 coinc (R9 latency)", coinc_o, ec);
                        check("R7 strobe", count_strobe_o, es);
                        check("R8 data", data_o, md ? es : ec);
                        check("R6 err", mask_err_o, err_exp);
                    end
                end
            end
        end
        // R6: flag stays set after a legal word returns.
        @(negedge clk); level_mask_i = 4'b0100; tpulse_i = 4'b0111; count_mode_i = 1'b0;
        @(posedge clk); #1;
        check("R6 sticky after legal mask", mask_err_o, 1'b1);
        check("R3 legal mask after error", coinc_o, 1'b1);
        // R9: single pulse shows exactly one cycle later, then clears.
        @(negedge clk); level_mask_i = 4'b0001; tpulse_i = 4'b0000;
        @(posedge clk); #1;
        check("R9 idle low", coinc_o, 1'b0);
        @(negedge clk); tpulse_i = 4'b1000;
        #1 check("R9 no combinational path", coinc_o, 1'b0);
        @(posedge clk); #1;
        check("R9 one-cycle latency", coinc_o, 1'b1);
        @(negedge clk); tpulse_i = 4'b0000;
        @(posedge clk); #1;
        check("R9 pulse ends", coinc_o, 1'b0);
        do_reset();
        check("R6 cleared by reset", mask_err_o, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule